// File: doc/BRIEF.md
# Descriptor-Ring Audio DMA Channel

This block moves 16-bit audio halfwords between a word-wide memory and a small sample FIFO that it shares with a codec. Memory holds a chain of four-word descriptors. Each descriptor gives a buffer address, a count word, a link to the next descriptor and one spare word. Software closes the chain into a ring, so once the channel starts it keeps cycling through the buffers until software stops it. The memory model sits inside the block and serves both descriptor fetches and data beats. A test-load port fills the memory and a peek port reads it back.

In transmit mode the channel fetches halfwords from memory and pushes them into the FIFO window, and the codec pops them. In receive mode the codec pushes halfwords, and the channel writes them to memory once enough have collected. The control word sets the direction and places the FIFO window inside the shared storage. It also sets the fill threshold that starts a receive drain. The channel shows its descriptor pointer and its current buffer pointer, so software can follow progress. It raises an interrupt flag whenever a descriptor whose interrupt enable is set runs out of bytes.

Top module: `audio_ring_dma`

## Requirements
- R1: After reset the control readback, descriptor pointer, current buffer pointer, FIFO level and interrupt flag are all zero, and the channel is inactive.
- R2: The control word has the following layout: bit 0 is active, bit 1 is load, bit 2 is receive and bit 3 is the read-only interrupt flag. Bits [15:8] hold the threshold in halfwords, bits [23:16] the window begin and bits [31:24] the window end, both in doublewords of four halfwords. The load bit reads back as 0. A control write with the load bit clear changes nothing.
- R3: A control write with load and active set does three things. It latches the fields, empties the FIFO and fetches the descriptor at the descriptor pointer. In that descriptor, byte offset +0 is the buffer address, +4 is the count word (bits [15:0] hold the byte count, bit 31 the interrupt enable) and +8 is the next-descriptor address.
- R4: A control write with load set and active clear halts the channel. The fields keep their values, the active bit clears and no further beats take place.
- R5: In transmit mode, halfwords go into the FIFO in ascending address order while the FIFO level is below the window size. The halfword at a byte address with bit 1 clear is bits [31:16] of its word, and the codec pops them first-in first-out.
- R6: Each beat moves 2 bytes and lowers the byte count by 2. The channel fetches the next descriptor only once the count is used up, and the next-descriptor address becomes the descriptor pointer at that point.
- R7: A chain whose last link points back to its first descriptor repeats its buffers without end.
- R8: The current buffer pointer takes the buffer address when a descriptor is fetched and then advances by 2 on every beat.
- R9: When a descriptor with its interrupt enable set completes, the interrupt flag is set. The flag stays set until a control read strobe or a control write with load set. A descriptor without the enable leaves the flag unchanged.
- R10: In receive mode nothing is written to memory until the FIFO level reaches the threshold. From then on the channel drains the FIFO into memory until it is empty.
- R11: A codec push takes effect only in receive mode while the level is below the window size. A codec pop takes effect only in transmit mode while the FIFO is not empty. Any other push or pop leaves the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctlWr | input | 1 | Control register write strobe |
| ctlRd | input | 1 | Control register read strobe, clears the interrupt flag |
| dptrWr | input | 1 | Descriptor pointer write strobe |
| regWrData | input | 32 | Write data for both registers |
| ctlRdData | output | 32 | Control register readback |
| descPtrOut | output | 32 | Current descriptor pointer |
| curBufPtr | output | 32 | Current buffer pointer |
| irqFlag | output | 1 | Channel interrupt flag |
| chanActive | output | 1 | Channel running |
| fifoPush | input | 1 | Codec push strobe (receive) |
| fifoIn | input | 16 | Codec push data |
| fifoPop | input | 1 | Codec pop strobe (transmit) |
| fifoOut | output | 16 | FIFO head halfword |
| fifoLevel | output | LVL_W | FIFO fill in halfwords |
| memLoadEn | input | 1 | Test-load write strobe for the memory model |
| memLoadAddr | input | MEM_AW | Test-load word index |
| memLoadData | input | 32 | Test-load word |
| memPeekAddr | input | MEM_AW | Peek word index |
| memPeekData | output | 32 | Peek word |

## Verification
The hardest condition to reach is the moment a ring wraps while the FIFO is full. At that point the channel has already fetched the first descriptor again and sits stalled with the buffer pointer at the first buffer. The interrupt from the earlier pass must still be pending. The bench reaches it in transmit mode: it starts a two-descriptor ring with no pops, waits until the window fills, then releases space four halfwords at a time. Each release lets exactly one block complete, so each interrupt-enable setting can be checked on its own. In receive mode, pushes below and then at the threshold separate the hold phase from the drain phase. A burst of pushes then crosses a block end and overwrites the start of the same buffer.

// File: rtl/ardma_pkg.sv
`timescale 1ns/1ps
package ardma_pkg;
  // control word bit positions
  localparam int CTL_ACT  = 0;
  localparam int CTL_LOAD = 1;
  localparam int CTL_RCV  = 2;
  localparam int CTL_IRQ  = 3;
  localparam int CNT_IE   = 31;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BUF,
    ST_CNT,
    ST_NXT,
    ST_XFER
  } dmaState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic fetchBuf;
    logic fetchCnt;
    logic fetchNext;
    logic beat;
    logic complete;
  } dmaStrobe_t;
endpackage

// File: rtl/ardma_mem.sv
`timescale 1ns/1ps
module ardma_mem #(
  parameter int WORDS = 256,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic [31:0]   chanAddr,
  input  logic          chanWe,
  input  logic [15:0]   chanWdata,
  output logic [31:0]   chanRdata,
  input  logic          loadEn,
  input  logic [AW-1:0] loadAddr,
  input  logic [31:0]   loadData,
  input  logic [AW-1:0] peekAddr,
  output logic [31:0]   peekData
);
  logic [31:0] words [WORDS];

  logic [AW-1:0] idx;
  logic inRange;
  assign idx = chanAddr[AW+1:2];
  // odd or out-of-range byte addresses read zero and drop writes
  assign inRange = (chanAddr[31:AW+2] == '0) && !chanAddr[0];

  assign chanRdata = inRange ? words[idx] : '0;
  assign peekData  = words[peekAddr];

  always_ff @(posedge clk) begin
    if (loadEn) begin
      words[loadAddr] <= loadData;
    end else if (chanWe && inRange) begin
      if (chanAddr[1]) words[idx][15:0]  <= chanWdata;
      else             words[idx][31:16] <= chanWdata;
    end
  end
endmodule

// File: rtl/ardma_ctrl.sv
`timescale 1ns/1ps
module ardma_ctrl
  import ardma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       stopReq,
  input  logic       cntZero,
  input  logic       cntLast,
  input  logic       moveReady,
  output dmaStrobe_t strobe
);
  dmaState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (stopReq) begin
      stateNext = ST_IDLE;
    end else if (startReq) begin
      stateNext = ST_BUF;
    end else begin
      case (state)
        ST_BUF: begin
          strobe.fetchBuf = 1'b1;
          stateNext = ST_CNT;
        end
        ST_CNT: begin
          strobe.fetchCnt = 1'b1;
          stateNext = ST_NXT;
        end
        ST_NXT: begin
          strobe.fetchNext = 1'b1;
          stateNext = ST_XFER;
        end
        ST_XFER: begin
          if (cntZero) begin
            strobe.complete = 1'b1;
            stateNext = ST_BUF;
          end else if (moveReady) begin
            strobe.beat = 1'b1;
            if (cntLast) begin
              strobe.complete = 1'b1;
              stateNext = ST_BUF;
            end
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/ardma_datapath.sv
`timescale 1ns/1ps
module ardma_datapath
  import ardma_pkg::*;
#(
  parameter int FIFO_HW = 32,
  localparam int PTR_W = $clog2(FIFO_HW),
  localparam int LVL_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWr,
  input  logic             ctlRd,
  input  logic             dptrWr,
  input  logic [31:0]      regWrData,
  input  dmaStrobe_t       strobe,
  output logic             startReq,
  output logic             stopReq,
  output logic             cntZero,
  output logic             cntLast,
  output logic             moveReady,
  output logic [31:0]      ctlRdData,
  output logic [31:0]      descPtr,
  output logic [31:0]      curBuf,
  output logic             irqFlag,
  output logic             active,
  input  logic             fifoPush,
  input  logic [15:0]      fifoIn,
  input  logic             fifoPop,
  output logic [15:0]      fifoOut,
  output logic [LVL_W-1:0] fifoLevel,
  output logic [31:0]      memAddr,
  output logic             memWe,
  output logic [15:0]      memWdata,
  input  logic [31:0]      memRdata
);
  logic [7:0]  hwmMark, winBeg, winEnd;
  logic        rcvMode;
  logic [31:0] nextDesc;
  logic [15:0] byteCnt;
  logic        blkIrqEn;

  logic [15:0]      store [FIFO_HW];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [LVL_W-1:0] level;
  logic             drainArm;

  logic loadWr;
  assign loadWr   = ctlWr & regWrData[CTL_LOAD];
  assign startReq = loadWr & regWrData[CTL_ACT];
  assign stopReq  = loadWr & ~regWrData[CTL_ACT];

  // window geometry, doublewords to halfwords
  logic [9:0]       winSpan;
  logic [LVL_W-1:0] winSize;
  logic [PTR_W-1:0] winBase, winTop, newBase;
  assign winSpan = {2'b00, winEnd} - {2'b00, winBeg};
  assign winSize = LVL_W'({winSpan, 2'b00});
  assign winBase = PTR_W'({winBeg, 2'b00});
  assign winTop  = PTR_W'({2'b00, winEnd, 2'b00} - 12'd1);
  assign newBase = PTR_W'({regWrData[23:16], 2'b00});

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == winTop) ? winBase : p + 1'b1;
  endfunction

  logic        pushEn, popEn, notEmpty;
  logic [15:0] memHalf, pushData;
  assign notEmpty = (level != '0);
  assign memHalf  = curBuf[1] ? memRdata[15:0] : memRdata[31:16];
  assign pushEn   = rcvMode ? (fifoPush & (level < winSize)) : strobe.beat;
  assign popEn    = rcvMode ? strobe.beat : (fifoPop & notEmpty);
  assign pushData = rcvMode ? fifoIn : memHalf;

  assign moveReady = rcvMode ? (drainArm & notEmpty) : (level < winSize);
  assign cntZero   = (byteCnt == 16'd0);
  assign cntLast   = (byteCnt <= 16'd2);

  always_comb begin
    if (strobe.fetchBuf)       memAddr = descPtr;
    else if (strobe.fetchCnt)  memAddr = descPtr + 32'd4;
    else if (strobe.fetchNext) memAddr = descPtr + 32'd8;
    else                       memAddr = curBuf;
  end
  assign memWe    = strobe.beat & rcvMode;
  assign memWdata = store[rdPtr];
  assign fifoOut  = store[rdPtr];
  assign fifoLevel = level;

  assign ctlRdData = {winEnd, winBeg, hwmMark, 4'b0000, irqFlag, rcvMode, 1'b0, active};

  // control register and interrupt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {hwmMark, winBeg, winEnd} <= '0;
      rcvMode <= 1'b0;
      active  <= 1'b0;
      irqFlag <= 1'b0;
    end else begin
      if (startReq) begin
        hwmMark <= regWrData[15:8];
        winBeg  <= regWrData[23:16];
        winEnd  <= regWrData[31:24];
        rcvMode <= regWrData[CTL_RCV];
        active  <= 1'b1;
      end else if (stopReq) begin
        active <= 1'b0;
      end
      if (strobe.complete && blkIrqEn) irqFlag <= 1'b1;
      else if (ctlRd || loadWr)        irqFlag <= 1'b0;
    end
  end

  // descriptor state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descPtr  <= '0;
      curBuf   <= '0;
      nextDesc <= '0;
      byteCnt  <= '0;
      blkIrqEn <= 1'b0;
    end else begin
      if (dptrWr)               descPtr <= regWrData;
      else if (strobe.complete) descPtr <= nextDesc;
      if (strobe.fetchBuf)  curBuf <= memRdata;
      else if (strobe.beat) curBuf <= curBuf + 32'd2;
      if (strobe.fetchCnt) begin
        byteCnt  <= memRdata[15:0];
        blkIrqEn <= memRdata[CNT_IE];
      end else if (strobe.beat) begin
        byteCnt <= cntLast ? 16'd0 : byteCnt - 16'd2;
      end
      if (strobe.fetchNext) nextDesc <= memRdata;
    end
  end

  // FIFO pointers, level and drain hysteresis
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr    <= '0;
      wrPtr    <= '0;
      level    <= '0;
      drainArm <= 1'b0;
    end else if (startReq) begin
      rdPtr    <= newBase;
      wrPtr    <= newBase;
      level    <= '0;
      drainArm <= 1'b0;
    end else begin
      if (pushEn) wrPtr <= stepPtr(wrPtr);
      if (popEn)  rdPtr <= stepPtr(rdPtr);
      case ({pushEn, popEn})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      if (notEmpty && (16'(level) >= 16'(hwmMark))) drainArm <= 1'b1;
      else if (!notEmpty)                           drainArm <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (pushEn) store[wrPtr] <= pushData;
  end
endmodule

// File: rtl/audio_ring_dma.sv
`timescale 1ns/1ps
module audio_ring_dma
  import ardma_pkg::*;
#(
  parameter int FIFO_HW = 32,
  parameter int MEM_WORDS = 256,
  localparam int LVL_W = $clog2(FIFO_HW) + 1,
  localparam int MEM_AW = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWr,
  input  logic              ctlRd,
  input  logic              dptrWr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       ctlRdData,
  output logic [31:0]       descPtrOut,
  output logic [31:0]       curBufPtr,
  output logic              irqFlag,
  output logic              chanActive,
  input  logic              fifoPush,
  input  logic [15:0]       fifoIn,
  input  logic              fifoPop,
  output logic [15:0]       fifoOut,
  output logic [LVL_W-1:0]  fifoLevel,
  input  logic              memLoadEn,
  input  logic [MEM_AW-1:0] memLoadAddr,
  input  logic [31:0]       memLoadData,
  input  logic [MEM_AW-1:0] memPeekAddr,
  output logic [31:0]       memPeekData
);
  dmaStrobe_t  strobe;
  logic        startReq, stopReq, cntZero, cntLast, moveReady;
  logic [31:0] chanAddr, chanRdata;
  logic        chanWe;
  logic [15:0] chanWdata;

  ardma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .startReq(startReq), .stopReq(stopReq),
    .cntZero(cntZero), .cntLast(cntLast), .moveReady(moveReady),
    .strobe(strobe)
  );

  ardma_datapath #(.FIFO_HW(FIFO_HW)) u_dp (
    .clk(clk), .rstN(rstN),
    .ctlWr(ctlWr), .ctlRd(ctlRd), .dptrWr(dptrWr), .regWrData(regWrData),
    .strobe(strobe),
    .startReq(startReq), .stopReq(stopReq),
    .cntZero(cntZero), .cntLast(cntLast), .moveReady(moveReady),
    .ctlRdData(ctlRdData), .descPtr(descPtrOut), .curBuf(curBufPtr),
    .irqFlag(irqFlag), .active(chanActive),
    .fifoPush(fifoPush), .fifoIn(fifoIn), .fifoPop(fifoPop),
    .fifoOut(fifoOut), .fifoLevel(fifoLevel),
    .memAddr(chanAddr), .memWe(chanWe), .memWdata(chanWdata),
    .memRdata(chanRdata)
  );

  ardma_mem #(.WORDS(MEM_WORDS)) u_mem (
    .clk(clk),
    .chanAddr(chanAddr), .chanWe(chanWe), .chanWdata(chanWdata),
    .chanRdata(chanRdata),
    .loadEn(memLoadEn), .loadAddr(memLoadAddr), .loadData(memLoadData),
    .peekAddr(memPeekAddr), .peekData(memPeekData)
  );
endmodule

// File: rtl/ardma_checker.sv
`timescale 1ns/1ps
module ardma_checker #(
  parameter int LVL_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctlWr,
  input logic             ctlRd,
  input logic [1:0]       wrLow,
  input logic [7:0]       winEnd,
  input logic [7:0]       winBeg,
  input logic             rcvMode,
  input logic             irqFlag,
  input logic             chanActive,
  input logic [31:0]      curBufPtr,
  input logic [31:0]      fieldsRd,
  input logic [LVL_W-1:0] fifoLevel,
  input logic             beat,
  input logic             memWe
);
  logic [11:0] winHalves, lvl12;
  assign winHalves = ({4'b0, winEnd} - {4'b0, winBeg}) << 2;
  assign lvl12     = 12'(fifoLevel);

  assert_ignore_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && !wrLow[1]) |=> $stable(fieldsRd));

  assert_stop_halts_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && wrLow[1] && !wrLow[0]) |=> !chanActive);

  assert_idle_pointer_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!chanActive && !ctlWr) |=> $stable(curBufPtr));

  assert_tx_room_R5: assert property (@(posedge clk) disable iff (!rstN)
    (beat && !rcvMode) |-> (lvl12 < winHalves));

  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !ctlRd && !ctlWr) |=> irqFlag);

  assert_rx_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (rcvMode && fifoLevel != '0));

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rstN)
    lvl12 <= winHalves);
endmodule

bind audio_ring_dma ardma_checker #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .ctlRd(ctlRd),
  .wrLow(regWrData[1:0]),
  .winEnd(ctlRdData[31:24]), .winBeg(ctlRdData[23:16]), .rcvMode(ctlRdData[2]),
  .irqFlag(irqFlag), .chanActive(chanActive), .curBufPtr(curBufPtr),
  .fieldsRd({ctlRdData[31:8], ctlRdData[3:0]}),
  .fifoLevel(fifoLevel), .beat(strobe.beat), .memWe(chanWe)
);

// File: tb/audio_ring_dma_bench.sv
`timescale 1ns/1ps
module audio_ring_dma_bench;
  localparam int LVL_W = 6;
  localparam int MEM_AW = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              ctlWr = 1'b0, ctlRd = 1'b0, dptrWr = 1'b0;
  logic [31:0]       regWrData = '0;
  logic [31:0]       ctlRdData, descPtrOut, curBufPtr, memPeekData;
  logic              irqFlag, chanActive;
  logic              fifoPush = 1'b0, fifoPop = 1'b0;
  logic [15:0]       fifoIn = '0;
  logic [15:0]       fifoOut;
  logic [LVL_W-1:0]  fifoLevel;
  logic              memLoadEn = 1'b0;
  logic [MEM_AW-1:0] memLoadAddr = '0, memPeekAddr = '0;
  logic [31:0]       memLoadData = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  audio_ring_dma u_audio_ring_dma (
    .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .ctlRd(ctlRd), .dptrWr(dptrWr),
    .regWrData(regWrData), .ctlRdData(ctlRdData), .descPtrOut(descPtrOut),
    .curBufPtr(curBufPtr), .irqFlag(irqFlag), .chanActive(chanActive),
    .fifoPush(fifoPush), .fifoIn(fifoIn), .fifoPop(fifoPop),
    .fifoOut(fifoOut), .fifoLevel(fifoLevel),
    .memLoadEn(memLoadEn), .memLoadAddr(memLoadAddr), .memLoadData(memLoadData),
    .memPeekAddr(memPeekAddr), .memPeekData(memPeekData)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic memLoad(input logic [MEM_AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    memLoadEn = 1'b1; memLoadAddr = a; memLoadData = d;
    @(negedge clk);
    memLoadEn = 1'b0;
  endtask

  task automatic ctlWrite(input logic [31:0] v);
    @(negedge clk);
    ctlWr = 1'b1; regWrData = v;
    @(negedge clk);
    ctlWr = 1'b0;
  endtask

  task automatic dptrWrite(input logic [31:0] v);
    @(negedge clk);
    dptrWr = 1'b1; regWrData = v;
    @(negedge clk);
    dptrWr = 1'b0;
  endtask

  task automatic ctlReadPulse();
    @(negedge clk);
    ctlRd = 1'b1;
    @(negedge clk);
    ctlRd = 1'b0;
  endtask

  task automatic popExpect(input logic [15:0] exp, input string tag);
    @(negedge clk);
    checkEq(tag, {16'h0, fifoOut}, {16'h0, exp});
    fifoPop = 1'b1;
    @(negedge clk);
    fifoPop = 1'b0;
  endtask

  task automatic popRaw();
    @(negedge clk);
    fifoPop = 1'b1;
    @(negedge clk);
    fifoPop = 1'b0;
  endtask

  task automatic pushOne(input logic [15:0] v);
    @(negedge clk);
    fifoPush = 1'b1; fifoIn = v;
    @(negedge clk);
    fifoPush = 1'b0;
  endtask

  function automatic logic [31:0] peek(input logic [MEM_AW-1:0] a);
    memPeekAddr = a;
    return memPeekData;
  endfunction

  task automatic peekCheck(input logic [MEM_AW-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    memPeekAddr = a;
    #0.1;
    checkEq(tag, memPeekData, exp);
  endtask

  // memory image: tx ring at 0x000/0x010, rx self-loop at 0x040
  task automatic loadImage();
    memLoad(8'd0,  32'h0000_0100); memLoad(8'd1, 32'h8000_0008);
    memLoad(8'd2,  32'h0000_0010); memLoad(8'd3, 32'h0);
    memLoad(8'd4,  32'h0000_0120); memLoad(8'd5, 32'h0000_0008);
    memLoad(8'd6,  32'h0000_0000); memLoad(8'd7, 32'h0);
    memLoad(8'd16, 32'h0000_0200); memLoad(8'd17, 32'h8000_000C);
    memLoad(8'd18, 32'h0000_0040); memLoad(8'd19, 32'h0);
    memLoad(8'd64, 32'hA001_A002); memLoad(8'd65, 32'hA003_A004);
    memLoad(8'd72, 32'hB001_B002); memLoad(8'd73, 32'hB003_B004);
    memLoad(8'd128, 32'h0); memLoad(8'd129, 32'h0); memLoad(8'd130, 32'h0);
  endtask

  task automatic testReset();
    @(negedge clk);
    checkEq("R1 control readback", ctlRdData, 32'h0);
    checkEq("R1 descriptor pointer", descPtrOut, 32'h0);
    checkEq("R1 buffer pointer", curBufPtr, 32'h0);
    checkEq("R1 level", 32'(fifoLevel), 32'h0);
    checkEq("R1 irq/active", {30'h0, irqFlag, chanActive}, 32'h0);
  endtask

  task automatic testIgnoredWrite();
    ctlWrite(32'h0200_0401);   // active set, load clear
    waitCyc(5);
    checkEq("R2 write without load ignored", ctlRdData, 32'h0);
    checkEq("R2 still inactive", {31'h0, chanActive}, 32'h0);
  endtask

  task automatic testTxFill();
    dptrWrite(32'h0);
    ctlWrite(32'h0200_0403);   // end=2 beg=0 hwm=4 tx
    waitCyc(40);
    checkEq("R5 tx fill stops at window", 32'(fifoLevel), 32'd8);
    checkEq("R8 pointer at refetched first buffer", curBufPtr, 32'h100);
    checkEq("R7 chain wrapped to first descriptor", descPtrOut, 32'h0);
    checkEq("R2 readback with irq bit", ctlRdData, 32'h0200_0409);
    ctlReadPulse();
    @(negedge clk);
    checkEq("R9 read strobe clears irq", {31'h0, irqFlag}, 32'h0);
  endtask

  task automatic testTxRing();
    popExpect(16'hA001, "R5 pop 0"); popExpect(16'hA002, "R5 pop 1");
    popExpect(16'hA003, "R5 pop 2"); popExpect(16'hA004, "R5 pop 3");
    waitCyc(20);
    checkEq("R9 irq after enabled block", {31'h0, irqFlag}, 32'h1);
    checkEq("R6 next descriptor taken", descPtrOut, 32'h10);
    checkEq("R8 pointer at second buffer", curBufPtr, 32'h120);
    ctlReadPulse();
    popExpect(16'hB001, "R3 pop 4"); popExpect(16'hB002, "R3 pop 5");
    popExpect(16'hB003, "R3 pop 6"); popExpect(16'hB004, "R3 pop 7");
    waitCyc(20);
    checkEq("R9 no irq for disabled block", {31'h0, irqFlag}, 32'h0);
    checkEq("R7 ring back to first", descPtrOut, 32'h0);
    popExpect(16'hA001, "R7 ring pop 8"); popExpect(16'hA002, "R7 ring pop 9");
    popExpect(16'hA003, "R7 ring pop 10"); popExpect(16'hA004, "R7 ring pop 11");
    waitCyc(20);
    checkEq("R9 irq on second pass", {31'h0, irqFlag}, 32'h1);
  endtask

  task automatic testStop();
    logic [31:0] held;
    ctlWrite(32'h0000_0002);
    waitCyc(2);
    checkEq("R4 inactive after stop", {31'h0, chanActive}, 32'h0);
    checkEq("R4 fields kept", ctlRdData & 32'hFFFF_FF04, 32'h0200_0400);
    held = curBufPtr;
    popRaw(); popRaw();
    waitCyc(20);
    checkEq("R4 no refill while stopped", 32'(fifoLevel), 32'd6);
    checkEq("R4 pointer frozen", curBufPtr, held);
    repeat (6) popRaw();
    popRaw();
    @(negedge clk);
    checkEq("R11 pop on empty ignored", 32'(fifoLevel), 32'd0);
  endtask

  task automatic testRxThreshold();
    dptrWrite(32'h40);
    ctlWrite(32'h0402_0407);   // end=4 beg=2 hwm=4 rx
    @(negedge clk);
    checkEq("R9 load write clears irq, R2 rx readback", ctlRdData, 32'h0402_0405);
    waitCyc(10);
    pushOne(16'hC001); pushOne(16'hC002); pushOne(16'hC003);
    waitCyc(20);
    checkEq("R10 held below threshold", 32'(fifoLevel), 32'd3);
    peekCheck(8'd128, 32'h0, "R10 memory untouched below threshold");
    pushOne(16'hC004);
    waitCyc(20);
    checkEq("R10 drained to empty", 32'(fifoLevel), 32'd0);
    peekCheck(8'd128, 32'hC001_C002, "R10 first word");
    peekCheck(8'd129, 32'hC003_C004, "R10 second word");
    checkEq("R8 rx pointer", curBufPtr, 32'h208);
  endtask

  task automatic testRxRing();
    pushOne(16'hC005); pushOne(16'hC006); pushOne(16'hC007); pushOne(16'hC008);
    waitCyc(30);
    peekCheck(8'd130, 32'hC005_C006, "R6 block tail");
    peekCheck(8'd128, 32'hC007_C008, "R7 self ring overwrite");
    peekCheck(8'd129, 32'hC003_C004, "R7 untouched word");
    checkEq("R8 pointer after wrap", curBufPtr, 32'h204);
    checkEq("R9 rx irq", {31'h0, irqFlag}, 32'h1);
  endtask

  task automatic testOverflow();
    ctlWrite(32'h0402_FF07);   // threshold unreachable
    waitCyc(6);
    for (int i = 0; i < 10; i++) pushOne(16'(16'hD000 + i));
    waitCyc(10);
    checkEq("R11 push beyond window ignored", 32'(fifoLevel), 32'd8);
    checkEq("R10 nothing drained", curBufPtr, 32'h200);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    testReset();
    loadImage();
    testIgnoredWrite();
    testTxFill();
    testTxRing();
    testStop();
    testRxThreshold();
    testRxRing();
    testOverflow();
    summary();
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end
endmodule